// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock

This unit steers the operands of a five-stage pipeline (fetch, register read, ALU, memory, write-back). The register file has two read ports and one write port. It writes in the first half of a cycle and reads in the second half, so a result retiring in write-back is already visible to the register-read stage. The unit therefore only has to resolve producers that are one or two instructions ahead of a consumer.

While an instruction sits in the register-read stage, the unit compares each of its source register numbers against two producers. The first is the destination of the instruction now in the ALU stage, whose result will sit at the ALU output next cycle. The second is the destination of the instruction now in the memory stage, whose result will sit at the memory-stage output next cycle. The chosen operand selects are registered, so they are presented alongside the instruction when it enters the ALU stage.

When the ALU-stage producer is a load and the next instruction reads its destination, the value cannot be ready in time. The unit then raises a stall for one cycle, so fetch and the register-read slot hold their contents. One cycle later it marks the ALU stage as a bubble. On the retry, the load has moved to the memory stage and its data is forwarded from there.

Top module: `fwd_interlock_unit`

## Requirements
- R1: After reset, every operand select reads 0 (register file) and `ex_bubble_o` is low.
- R2: If a source register (nonzero) equals the ALU-stage destination with its write-enable set, and no stall occurs, then after the next rising edge that operand's select is 1 (ALU-output path).
- R3: If a source register (nonzero) equals the memory-stage destination with its write-enable set, and it does not match the ALU-stage producer, then after the next edge the select is 2 (memory-output path).
- R4: When both producers match the same source, the ALU-stage producer wins and the select is 1.
- R5: A producer whose write-enable is low never matches, and the select stays 0 unless the other producer matches.
- R6: Source register 0 always selects 0, and it never causes a stall, even when a producer writes register 0.
- R7: `stall_o` is high in the same cycle whenever the register-read slot is valid and a source it uses equals the nonzero destination of an ALU-stage load with write-enable set.
- R8: A source whose use flag is low, or a register-read slot marked invalid, never raises `stall_o`. An invalid slot enters the ALU stage with all selects at 0.
- R9: On the edge that ends a stall cycle, the ALU stage receives a bubble. `ex_bubble_o` is high for that one cycle and all selects read 0.
- R10: A load one stage further on (in the memory stage) with a dependent reader causes no stall, and the reader receives select 2. The load-use penalty is therefore one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid_i | input | 1 | Register-read slot holds a real instruction |
| rd_src_i | input | NUM_SRC x REG_AW | Source register numbers of the register-read instruction |
| rd_use_i | input | NUM_SRC | Per-source flag: the operand is actually read |
| alu_dst_i | input | REG_AW | Destination of the ALU-stage instruction |
| alu_we_i | input | 1 | ALU-stage instruction writes a register |
| alu_load_i | input | 1 | ALU-stage instruction is a load |
| mem_dst_i | input | REG_AW | Destination of the memory-stage instruction |
| mem_we_i | input | 1 | Memory-stage instruction writes a register |
| ex_sel_o | output | NUM_SRC x 2 | Registered operand selects for the ALU stage: 0 register file, 1 ALU output, 2 memory output |
| stall_o | output | 1 | Hold the PC and the fetch/read register this cycle |
| ex_bubble_o | output | 1 | The ALU stage holds an injected no-op with writes disabled |

## Verification
The bench builds the unit with its defaults: 5-bit register numbers and two source operands. These defaults reach register 0 and register 31, the two ends of the register range.

A scripted phase walks through each forwarding case, the priority case, and the disabled-write case. It then plays a full load-use sequence: the stall, the bubble, and the retry that reads from the memory stage. A pseudo-random phase then draws register numbers from a small set so that matches on both operands and on both producers occur often and together.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    SEL_RF  = 2'd0,
    SEL_ALU = 2'd1,
    SEL_MEM = 2'd2
  } opnd_sel_e;

  // Younger producer is checked first.
  function automatic opnd_sel_e pick_path(input logic hit_alu, input logic hit_mem);
    if (hit_alu)      return SEL_ALU;
    else if (hit_mem) return SEL_MEM;
    else              return SEL_RF;
  endfunction

endpackage

// File: rtl/fwd_operand_match.sv
module fwd_operand_match
  import fwd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_i,
  input  logic              use_i,
  input  logic [REG_AW-1:0] alu_dst_i,
  input  logic              alu_we_i,
  input  logic              alu_load_i,
  input  logic [REG_AW-1:0] mem_dst_i,
  input  logic              mem_we_i,
  output opnd_sel_e         sel_o,
  output logic              alu_hit_o,
  output logic              mem_hit_o,
  output logic              hazard_o
);

  function automatic logic reg_match(input logic [REG_AW-1:0] src,
                                     input logic [REG_AW-1:0] dst,
                                     input logic              we);
    return we && (src != '0) && (src == dst);
  endfunction

  always_comb begin
    alu_hit_o = reg_match(src_i, alu_dst_i, alu_we_i);
    mem_hit_o = reg_match(src_i, mem_dst_i, mem_we_i);
    sel_o     = pick_path(alu_hit_o, mem_hit_o);
    hazard_o  = use_i && alu_load_i && alu_hit_o;
  end

endmodule

// File: rtl/fwd_sel_stage.sv
module fwd_sel_stage
  import fwd_pkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   valid_i,
  input  logic                   stall_i,
  input  opnd_sel_e [NUM_SRC-1:0] sel_d_i,
  output opnd_sel_e [NUM_SRC-1:0] sel_q_o,
  output logic                   bubble_o
);

  logic pass_w;
  assign pass_w = valid_i && !stall_i;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sel
    always_ff @(posedge clk) begin
      if (!rst_n)       sel_q_o[i] <= SEL_RF;
      else if (pass_w)  sel_q_o[i] <= sel_d_i[i];
      else              sel_q_o[i] <= SEL_RF;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bubble_o <= 1'b0;
    else        bubble_o <= stall_i;
  end

endmodule

// File: rtl/fwd_interlock_unit.sv
module fwd_interlock_unit
  import fwd_pkg::*;
#(
  parameter int REG_AW  = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rd_valid_i,
  input  logic [NUM_SRC-1:0][REG_AW-1:0] rd_src_i,
  input  logic [NUM_SRC-1:0]             rd_use_i,
  input  logic [REG_AW-1:0]              alu_dst_i,
  input  logic                           alu_we_i,
  input  logic                           alu_load_i,
  input  logic [REG_AW-1:0]              mem_dst_i,
  input  logic                           mem_we_i,
  output logic [NUM_SRC-1:0][1:0]        ex_sel_o,
  output logic                           stall_o,
  output logic                           ex_bubble_o
);

  localparam int SEL_W = $bits(opnd_sel_e);

  opnd_sel_e [NUM_SRC-1:0] sel_next_w;
  opnd_sel_e [NUM_SRC-1:0] sel_cur_w;
  logic      [NUM_SRC-1:0] alu_hit_w;
  logic      [NUM_SRC-1:0] mem_hit_w;
  logic      [NUM_SRC-1:0] hazard_w;
  logic                    load_use_w;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_opnd
    fwd_operand_match #(.REG_AW(REG_AW)) u_match (
      .src_i      (rd_src_i[i]),
      .use_i      (rd_use_i[i]),
      .alu_dst_i  (alu_dst_i),
      .alu_we_i   (alu_we_i),
      .alu_load_i (alu_load_i),
      .mem_dst_i  (mem_dst_i),
      .mem_we_i   (mem_we_i),
      .sel_o      (sel_next_w[i]),
      .alu_hit_o  (alu_hit_w[i]),
      .mem_hit_o  (mem_hit_w[i]),
      .hazard_o   (hazard_w[i])
    );
    assign ex_sel_o[i] = SEL_W'(sel_cur_w[i]);
  end

  assign load_use_w = rd_valid_i && (|hazard_w);
  assign stall_o    = load_use_w;

  fwd_sel_stage #(.NUM_SRC(NUM_SRC)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (rd_valid_i),
    .stall_i  (load_use_w),
    .sel_d_i  (sel_next_w),
    .sel_q_o  (sel_cur_w),
    .bubble_o (ex_bubble_o)
  );

endmodule

// File: rtl/fwd_interlock_chk.sv
module fwd_interlock_chk #(
  parameter int REG_AW  = 5,
  parameter int NUM_SRC = 2
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           rd_valid_i,
  input logic [NUM_SRC-1:0][REG_AW-1:0] rd_src_i,
  input logic [NUM_SRC-1:0]             rd_use_i,
  input logic [REG_AW-1:0]              alu_dst_i,
  input logic                           alu_we_i,
  input logic                           alu_load_i,
  input logic [REG_AW-1:0]              mem_dst_i,
  input logic                           mem_we_i,
  input logic [NUM_SRC-1:0][1:0]        ex_sel_o,
  input logic                           stall_o,
  input logic                           ex_bubble_o,
  input logic [NUM_SRC-1:0]             hazard_w
);

  // R9: a stall is followed by a bubble
  a_r9_bubble_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> ex_bubble_o);

  // R9: a bubble carries no forwarding
  a_r9_bubble_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    ex_bubble_o |-> (ex_sel_o == '0));

  // R7, R6: a stall needs a nonzero ALU-stage load that writes
  a_r7_stall_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> (alu_load_i && alu_we_i && (alu_dst_i != '0)));

  // R8: an empty register-read slot never stalls
  a_r8_invalid_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_i |-> !stall_o);

  // R5: with both producers not writing, every select is the register file
  a_r5_no_we_rf: assert property (@(posedge clk) disable iff (!rst_n)
    (!alu_we_i && !mem_we_i) |=> (ex_sel_o == '0));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    // R8: an unused source cannot create a hazard
    a_r8_unused_no_hazard: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_use_i[i] |-> !hazard_w[i]);

    // R6: register 0 is never forwarded
    a_r6_zero_rf: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_src_i[i] == '0) |=> (ex_sel_o[i] == 2'd0));

    // R4, R2: an ALU-stage match takes the ALU path
    a_r4_alu_first: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid_i && !stall_o && alu_we_i && (alu_dst_i != '0) &&
       (rd_src_i[i] == alu_dst_i)) |=> (ex_sel_o[i] == 2'd1));
  end

endmodule

bind fwd_interlock_unit fwd_interlock_chk #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_valid_i  (rd_valid_i),
  .rd_src_i    (rd_src_i),
  .rd_use_i    (rd_use_i),
  .alu_dst_i   (alu_dst_i),
  .alu_we_i    (alu_we_i),
  .alu_load_i  (alu_load_i),
  .mem_dst_i   (mem_dst_i),
  .mem_we_i    (mem_we_i),
  .ex_sel_o    (ex_sel_o),
  .stall_o     (stall_o),
  .ex_bubble_o (ex_bubble_o),
  .hazard_w    (hazard_w)
);

// File: tb/sim_fwd_interlock_unit.sv
`timescale 1ns/1ps
module sim_fwd_interlock_unit;

  localparam int AW = 5;
  localparam int NS = 2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               rd_valid = 1'b0;
  logic [NS-1:0][AW-1:0] rd_src = '0;
  logic [NS-1:0]      rd_use = '0;
  logic [AW-1:0]      alu_dst = '0;
  logic               alu_we = 1'b0;
  logic               alu_load = 1'b0;
  logic [AW-1:0]      mem_dst = '0;
  logic               mem_we = 1'b0;
  logic [NS-1:0][1:0] ex_sel;
  logic               stall;
  logic               ex_bubble;

  int n_checks = 0;
  int n_fail   = 0;

  logic [2*NS:0] exp_q[$];
  string         tag_q[$];

  always #4 clk = ~clk;

  fwd_interlock_unit #(.REG_AW(AW), .NUM_SRC(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_valid_i(rd_valid), .rd_src_i(rd_src),
    .rd_use_i(rd_use), .alu_dst_i(alu_dst), .alu_we_i(alu_we),
    .alu_load_i(alu_load), .mem_dst_i(mem_dst), .mem_we_i(mem_we),
    .ex_sel_o(ex_sel), .stall_o(stall), .ex_bubble_o(ex_bubble)
  );

  // Reference: which path a source should take next cycle
  function automatic logic [1:0] ref_path(input logic [AW-1:0] s);
    logic [1:0] r;
    r = 2'd0;
    if (mem_we && mem_dst == s) r = 2'd2;
    if (alu_we && alu_dst == s) r = 2'd1;
    if (s == '0) r = 2'd0;
    return r;
  endfunction

  function automatic logic ref_stall();
    logic h;
    h = 1'b0;
    for (int k = 0; k < NS; k++)
      if (rd_use[k] && rd_src[k] != '0 && alu_load && alu_we && alu_dst == rd_src[k])
        h = 1'b1;
    return rd_valid && h;
  endfunction

  task automatic report(input string req, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [AW-1:0] sa, input logic [AW-1:0] sb,
                       input logic ua, input logic ub,
                       input logic [AW-1:0] ad, input logic awe, input logic ald,
                       input logic [AW-1:0] md, input logic mwe, input string req);
    logic          es;
    logic [2*NS:0] item;
    @(negedge clk);
    rd_valid = v; rd_src[0] = sa; rd_src[1] = sb; rd_use = {ub, ua};
    alu_dst = ad; alu_we = awe; alu_load = ald; mem_dst = md; mem_we = mwe;
    #1;
    es = ref_stall();
    report(req, "stall", {31'd0, stall}, {31'd0, es});
    item = '0;
    item[2*NS] = es;
    if (v && !es)
      for (int k = 0; k < NS; k++) item[2*k +: 2] = ref_path(rd_src[k]);
    exp_q.push_back(item);
    tag_q.push_back(req);
  endtask

  // Monitor: compare registered outputs after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [2*NS:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        report(t, "ex_sel/bubble", {27'd0, ex_bubble, ex_sel}, {27'd0, e});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(posedge clk);
    #2;
    report("R1", "reset sel", {30'd0, ex_sel}, 32'd0);
    report("R1", "reset bubble", {31'd0, ex_bubble}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // R2 ALU path on operand a, R3 memory path on operand b
    drive(1, 5'd3, 5'd4, 1, 1, 5'd3, 1, 0, 5'd4, 1, "R2");
    drive(1, 5'd9, 5'd6, 1, 1, 5'd1, 1, 0, 5'd6, 1, "R3");
    // R4 both producers match
    drive(1, 5'd8, 5'd8, 1, 1, 5'd8, 1, 0, 5'd8, 1, "R4");
    // R5 write-enables low
    drive(1, 5'd8, 5'd2, 1, 1, 5'd8, 0, 0, 5'd2, 0, "R5");
    drive(1, 5'd8, 5'd2, 1, 1, 5'd8, 0, 1, 5'd8, 1, "R5");
    // R6 register 0 with a load writing register 0
    drive(1, 5'd0, 5'd0, 1, 1, 5'd0, 1, 1, 5'd0, 1, "R6");
    // R7 load-use stall, R9 bubble, R10 retry via memory path
    drive(1, 5'd7, 5'd31, 1, 1, 5'd7, 1, 1, 5'd2, 1, "R7");
    drive(1, 5'd7, 5'd31, 1, 1, 5'd0, 0, 0, 5'd7, 1, "R10");
    // R9 again on operand b at register 31
    drive(1, 5'd1, 5'd31, 1, 1, 5'd31, 1, 1, 5'd0, 0, "R9");
    drive(1, 5'd1, 5'd31, 1, 1, 5'd5, 1, 0, 5'd31, 1, "R10");
    // R8 unused operand and invalid slot
    drive(1, 5'd1, 5'd12, 1, 0, 5'd12, 1, 1, 5'd0, 0, "R8");
    drive(0, 5'd12, 5'd12, 1, 1, 5'd12, 1, 1, 5'd12, 1, "R8");
    // Mixed patterns
    lf = 32'h1234_5677;
    for (int n = 0; n < 300; n++) begin
      lf = lf * 32'd1664525 + 32'd1013904223;
      drive(lf[31:29] != 3'd0, {3'd0, lf[1:0]}, {3'd0, lf[3:2]}, lf[4], lf[5],
            {3'd0, lf[7:6]}, lf[8], lf[9], {3'd0, lf[11:10]}, lf[12], "R7");
    end
    drive(0, 5'd0, 5'd0, 0, 0, 5'd0, 0, 0, 5'd0, 0, "R8");
    while (exp_q.size() > 0) @(posedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule